// File: doc/BRIEF.md
# SPI Hold Condition Gate

This block sits between the serial-interface pins of a small serial memory and its protocol engine. It resynchronises the serial clock, chip select, pause input and serial data into the system clock domain. It then decides, in that domain, whether the serial link is paused. While the link is paused, the protocol engine receives no serial-clock strobes, so its bit counter and shift registers keep their values. The transfer then carries on at the bit where it stopped. The serial output is forced to high impedance for the whole pause.

Pause entry and exit happen only while the resynchronised serial clock is low. A change of the pause input that arrives while the clock is high is held back until the next falling clock edge. That falling edge is already judged with the new pause state. Releasing chip select during a pause clears the pause and raises a one-cycle abort strobe, which the engine uses to drop the transaction in progress.

Top module: `spi_hold_gate`

## Requirements
- R1: While `rst` is high, `hold_active_o`, `clk_qual_en_o`, `sck_rise_o`, `sck_fall_o` and `eng_abort_o` are 0 and `so_hiz_o` is 1.
- R2: Every pin passes through SYNC_STAGES (default 2) flops, so `sdi_o` equals `sdi_pin` as it stood SYNC_STAGES clock edges earlier.
- R3: A pause starts when the synchronised device is selected (chip select low), the synchronised serial clock is low and the synchronised pause input is low. `hold_active_o` is 1 from the next edge.
- R4: A pause ends when the synchronised pause input is high while selected and the synchronised serial clock is low. `hold_active_o` is 0 from the next edge.
- R5: While the synchronised serial clock is high and the device is selected, `hold_active_o` keeps its value whatever the pause input does.
- R6: A synchronised falling clock edge that coincides with a deferred pause entry gives no `sck_fall_o`. One that coincides with a deferred pause exit gives `sck_fall_o`.
- R7: `clk_qual_en_o` is 1 exactly when the device is selected and the pause state of the next edge is inactive. While it is 0, neither `sck_rise_o` nor `sck_fall_o` pulses.
- R8: `so_hiz_o` is 1 whenever `hold_active_o` is 1 or the synchronised chip select is high.
- R9: No pause starts while deselected. A synchronised deselect clears `hold_active_o` at the next edge.
- R10: `eng_abort_o` pulses for one cycle when the synchronised chip select rises while `hold_active_o` is 1. It never pulses otherwise.
- R11: `sck_rise_o` and `sck_fall_o` pulse for one cycle on the synchronised rising and falling clock transitions, and only while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_pin | input | 1 | Serial clock pin (asynchronous) |
| cs_n_pin | input | 1 | Chip select pin, active low (asynchronous) |
| hold_n_pin | input | 1 | Pause input pin, active low (asynchronous) |
| sdi_pin | input | 1 | Serial data input pin (asynchronous) |
| sdi_o | output | 1 | Synchronised serial data to the engine |
| sck_rise_o | output | 1 | Qualified rising serial-clock strobe |
| sck_fall_o | output | 1 | Qualified falling serial-clock strobe |
| clk_qual_en_o | output | 1 | Serial-clock qualify enable |
| hold_active_o | output | 1 | Registered pause flag (engine freeze) |
| so_hiz_o | output | 1 | Serial output high-impedance override |
| eng_abort_o | output | 1 | One-cycle abort strobe for the engine |

## Verification
Two things can land in one cycle: a synchronised falling clock edge and a pause transition that was deferred while the clock was high. The bench provokes this on purpose. It changes the pause pin while the clock is high and then lowers the clock, in both the entry and the exit direction. It then judges whether the fall strobe was swallowed or delivered, and on which edge `hold_active_o` moved. A second collision is a deselect landing in the same cycle as a pause that is active. The abort strobe and the clearing of the pause are checked together in that cycle. Random pin traffic then mixes all of these against a cycle model of the requirements.

// File: rtl/spi_hold_gate_pkg.sv
package spi_hold_gate_pkg;

    // Synchronised view of the serial pins
    typedef struct packed {
        logic sck;
        logic cs_n;
        logic hold_n;
        logic sdi;
    } pin_vec_t;

    localparam int PIN_W = $bits(pin_vec_t);

    // Idle (reset) level of every pin: clock low, deselected, no pause
    localparam pin_vec_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, hold_n: 1'b1, sdi: 1'b0};

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Pause state for the next edge: decided only while the clock is low
    function automatic logic pause_next(input logic sel, input logic sck_lvl,
                                        input logic hold_n_lvl, input logic cur);
        if (!sel)
            return 1'b0;
        else if (!sck_lvl)
            return ~hold_n_lvl;
        else
            return cur;
    endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync
    import spi_hold_gate_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins_i,
    output pin_vec_t pins_o
);
    localparam int LAST = STAGES - 1;

    pin_vec_t stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= PIN_IDLE;
                    else     stage_q[s] <= pins_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= PIN_IDLE;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign pins_o = stage_q[LAST];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge
    import spi_hold_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins_s,
    output edge_t    sck_e,
    output logic     cs_rise
);
    logic sck_prev_q;
    logic cs_n_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q  <= PIN_IDLE.sck;
            cs_n_prev_q <= PIN_IDLE.cs_n;
        end else begin
            sck_prev_q  <= pins_s.sck;
            cs_n_prev_q <= pins_s.cs_n;
        end
    end

    always_comb begin
        sck_e.rise = pins_s.sck & ~sck_prev_q;
        sck_e.fall = ~pins_s.sck & sck_prev_q;
        cs_rise    = pins_s.cs_n & ~cs_n_prev_q;
    end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins_s,
    input  edge_t    sck_e,
    input  logic     cs_rise,
    output logic     hold_q,
    output logic     qual_en,
    output edge_t    sck_q,
    output logic     abort,
    output logic     hiz
);
    logic sel;
    logic hold_d;

    always_comb begin
        sel     = ~pins_s.cs_n;
        hold_d  = pause_next(sel, pins_s.sck, pins_s.hold_n, hold_q);
        qual_en = sel & ~hold_d;
        sck_q.rise = sck_e.rise & qual_en;
        sck_q.fall = sck_e.fall & qual_en;
        abort   = cs_rise & hold_q;
        hiz     = hold_q | pins_s.cs_n;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= hold_d;
    end
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spi_hold_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic hold_n_pin,
    input  logic sdi_pin,
    output logic sdi_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic clk_qual_en_o,
    output logic hold_active_o,
    output logic so_hiz_o,
    output logic eng_abort_o
);
    pin_vec_t pins_raw;
    pin_vec_t pins_s;
    edge_t    sck_e;
    edge_t    sck_q;
    logic     cs_rise;

    always_comb begin
        pins_raw.sck    = sck_pin;
        pins_raw.cs_n   = cs_n_pin;
        pins_raw.hold_n = hold_n_pin;
        pins_raw.sdi    = sdi_pin;
    end

    spi_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_raw),
        .pins_o (pins_s)
    );

    spi_hold_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .pins_s  (pins_s),
        .sck_e   (sck_e),
        .cs_rise (cs_rise)
    );

    spi_hold_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .pins_s  (pins_s),
        .sck_e   (sck_e),
        .cs_rise (cs_rise),
        .hold_q  (hold_active_o),
        .qual_en (clk_qual_en_o),
        .sck_q   (sck_q),
        .abort   (eng_abort_o),
        .hiz     (so_hiz_o)
    );

    assign sdi_o      = pins_s.sdi;
    assign sck_rise_o = sck_q.rise;
    assign sck_fall_o = sck_q.fall;
endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
    input logic clk,
    input logic rst,
    input logic sck_s,
    input logic cs_n_s,
    input logic sck_rise_o,
    input logic sck_fall_o,
    input logic clk_qual_en_o,
    input logic hold_active_o,
    input logic so_hiz_o,
    input logic eng_abort_o
);
    p_hiz_in_pause_r8: assert property (@(posedge clk) disable iff (rst)
        hold_active_o |-> so_hiz_o);

    p_abort_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        eng_abort_o |=> !eng_abort_o);

    p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
        eng_abort_o |=> !hold_active_o);

    p_edges_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(sck_rise_o && sck_fall_o));

    p_no_strobe_unqualified_r7: assert property (@(posedge clk) disable iff (rst)
        !clk_qual_en_o |-> (!sck_rise_o && !sck_fall_o));

    p_defer_while_high_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(hold_active_o) && !$past(cs_n_s)) |-> !$past(sck_s));
endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sck_s         (pins_s.sck),
    .cs_n_s        (pins_s.cs_n),
    .sck_rise_o    (sck_rise_o),
    .sck_fall_o    (sck_fall_o),
    .clk_qual_en_o (clk_qual_en_o),
    .hold_active_o (hold_active_o),
    .so_hiz_o      (so_hiz_o),
    .eng_abort_o   (eng_abort_o)
);

// File: tb/spi_hold_gate_tb.sv
module spi_hold_gate_tb;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck_pin = 1'b0, cs_n_pin = 1'b1, hold_n_pin = 1'b1, sdi_pin = 1'b0;
    logic sdi_o, sck_rise_o, sck_fall_o, clk_qual_en_o, hold_active_o, so_hiz_o, eng_abort_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_hold_gate #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst), .sck_pin(sck_pin), .cs_n_pin(cs_n_pin),
        .hold_n_pin(hold_n_pin), .sdi_pin(sdi_pin), .sdi_o(sdi_o),
        .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o),
        .clk_qual_en_o(clk_qual_en_o), .hold_active_o(hold_active_o),
        .so_hiz_o(so_hiz_o), .eng_abort_o(eng_abort_o)
    );

    // ---- reference model: pin delay lines plus pause state ----
    logic [3:0] d1 = 4'b0100, d2 = 4'b0100; // {sck, cs_n, hold_n, sdi}
    logic m_psck = 0, m_pcs = 1, m_hold = 0;
    int   m_tag = 3;        // reason for the last pause-state value

    function automatic logic f_sel();      return !d2[2]; endfunction
    function automatic logic f_next();
        if (!f_sel()) return 1'b0;
        if (!d2[3])   return !d2[1];
        return m_hold;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            d1 = 4'b0110; d2 = 4'b0110; m_psck = 0; m_pcs = 1; m_hold = 0; m_tag = 3;
        end else begin
            logic nh;
            nh = f_next();
            if (!f_sel())           m_tag = 9;
            else if (d2[3])         m_tag = 5;
            else if (nh && !m_hold) m_tag = 3;
            else if (!nh && m_hold) m_tag = 4;
            else                    m_tag = nh ? 3 : 4;
            m_hold = nh;
            m_psck = d2[3]; m_pcs = d2[2];
            d2 = d1;
            d1 = {sck_pin, cs_n_pin, hold_n_pin, sdi_pin};
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic compare();
        logic nh, sel, erise, efall;
        sel = f_sel(); nh = f_next();
        erise = sel && d2[3] && !m_psck && !nh;
        efall = sel && !d2[3] && m_psck && !nh;
        if (rst) begin
            chk("R1 hold", hold_active_o, 1'b0);
            chk("R1 qual", clk_qual_en_o, 1'b0);
            chk("R1 rise", sck_rise_o, 1'b0);
            chk("R1 fall", sck_fall_o, 1'b0);
            chk("R1 abort", eng_abort_o, 1'b0);
            chk("R1 hiz", so_hiz_o, 1'b1);
            return;
        end
        chk("R2 sdi", sdi_o, d2[0]);
        case (m_tag)
            3: chk("R3 hold", hold_active_o, m_hold);
            4: chk("R4 hold", hold_active_o, m_hold);
            5: chk("R5 hold", hold_active_o, m_hold);
            default: chk("R9 hold", hold_active_o, m_hold);
        endcase
        chk("R7 qual", clk_qual_en_o, sel && !nh);
        if (!sel) begin
            chk("R11 rise", sck_rise_o, erise);
            chk("R11 fall", sck_fall_o, efall);
        end else if (m_hold || nh) begin
            chk("R7 rise", sck_rise_o, erise);
            chk("R6 fall", sck_fall_o, efall);
        end else begin
            chk("R11 rise", sck_rise_o, erise);
            chk("R11 fall", sck_fall_o, efall);
        end
        chk("R8 hiz", so_hiz_o, m_hold || d2[2]);
        chk("R10 abort", eng_abort_o, d2[2] && !m_pcs && m_hold);
    endtask

    // one cycle: compare at the falling edge, then drive the next pin values
    task automatic step(input logic s, input logic c, input logic h, input logic d);
        @(negedge clk);
        compare();
        sck_pin = s; cs_n_pin = c; hold_n_pin = h; sdi_pin = d;
    endtask

    task automatic hold_pins(input int n);
        for (int i = 0; i < n; i++) step(sck_pin, cs_n_pin, hold_n_pin, sdi_pin);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected finish");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset state
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0);
        @(negedge clk); rst = 1'b0;

        // R9: pause pin low while deselected does nothing
        step(0, 1, 0, 1); hold_pins(5);
        // select, pause still low with clock low -> R3 entry
        step(0, 0, 0, 1); hold_pins(5);
        // clock edges during pause must be swallowed (R7)
        step(1, 0, 0, 0); hold_pins(4); step(0, 0, 0, 1); hold_pins(4);
        // R4: release with clock low
        step(0, 0, 1, 0); hold_pins(4);
        // normal edges (R11)
        step(1, 0, 1, 1); hold_pins(3); step(0, 0, 1, 1); hold_pins(3);
        // R5/R6: pause asserted while clock high, then clock falls
        step(1, 0, 1, 0); hold_pins(4);
        step(1, 0, 0, 0); hold_pins(5);
        step(0, 0, 0, 0); hold_pins(4);
        // deferred exit: raise clock, release pause, then fall
        step(1, 0, 0, 0); hold_pins(4);
        step(1, 0, 1, 0); hold_pins(5);
        step(0, 0, 1, 0); hold_pins(4);
        // R10: deselect during pause -> abort and clear
        step(0, 0, 0, 0); hold_pins(4);
        step(0, 1, 0, 0); hold_pins(4);
        // deselect without pause -> no abort
        step(0, 0, 1, 0); hold_pins(4); step(0, 1, 1, 0); hold_pins(4);

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            logic s, c, h;
            s = sck_pin; c = cs_n_pin; h = hold_n_pin;
            if ($urandom_range(0, 2) == 0) s = ~s;
            if ($urandom_range(0, 40) == 0) c = ~c;
            if ($urandom_range(0, 9) == 0) h = ~h;
            step(s, c, h, 1'($urandom_range(0, 1)));
        end
        step(0, 1, 1, 0); hold_pins(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule